// File: doc/BRIEF.md
# Ternary/Binary Content-Addressable Lookup Table

The block is a small associative table of 64-bit entries used for address lookup. Each entry can hold an exact 64-bit value, such as a MAC address, or 32 ternary digits for prefix routing. Ternary digit n lives in the pair formed by bit n and bit n+32. A digit of 0 or 1 is stored as the value in the low bit and its complement in the high bit. A don't-care digit is stored as zeros in both bits. Both kinds of entry can sit side by side in the same table.

A host issues one command per clock through a valid/opcode port. The commands are:
- a prefix search with a 32-bit key;
- an exact search with a 64-bit key;
- a raw write by index;
- an encoded ternary write by index, which converts a value and a mask into the paired form;
- a write into the lowest free slot;
- a delete by index;
- a delete of the lowest entry that exactly matches a key.

A search returns a registered match flag and the lowest matching index, always one clock later whatever the table holds. Prefixes are placed with longer masks at lower indices, so the result is the longest-prefix match. Each write or delete that takes effect places its index on an address output, so that a companion RAM holding the associated data can be kept in step. A full flag tells the host when no slot is free.

Top module: `tcam_lookup`

## Requirements
- R1: After reset, every entry is invalid, and matchFlag, matchIndex, activeValid and full are all 0.
- R2: cmdOp encodings are 0 idle, 1 prefix search, 2 exact search, 3 raw write, 4 encoded write, 5 write-next-free, 6 delete by index and 7 delete by key; they act only while cmdValid is 1. A search loads matchFlag/matchIndex at the first clock edge after it is presented, and they are read one cycle after presentation. Every other command leaves them unchanged.
- R3: The encoded write takes value A = cmdData[31:0] and mask M = cmdData[63:32] (a mask bit of 0 means don't-care). It stores A&M in bits 31:0 and ~A&M in bits 63:32.
- R4: A prefix search uses key K = cmdData[31:0]. A valid entry matches when every digit n matches. A key bit of 1 matches a pair with bit n+32 equal to 0, and a key bit of 0 matches a pair with bit n equal to 0.
- R5: An exact search matches a valid entry only when all 64 stored bits equal cmdData.
- R6: When several entries match, matchIndex is the lowest of them. When none match, matchFlag is 0 and matchIndex is 0.
- R7: A raw or encoded write stores into entry cmdIndex and marks it valid. The cycle after, activeValid is 1 and activeAddr equals cmdIndex.
- R8: Write-next-free stores cmdData into the lowest invalid entry and reports that index on activeAddr. If the table is full, nothing changes and activeValid stays 0.
- R9: Delete by index clears the validity of entry cmdIndex and reports cmdIndex on activeAddr one cycle later.
- R10: Delete by key clears the lowest valid entry whose 64 bits equal cmdData and reports its index. With no such entry, nothing changes and activeValid stays 0.
- R11: full is 1 exactly when every entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command opcode |
| cmdIndex | input | IDX_W | Target index for indexed commands |
| cmdData | input | WORD_W | Write data, search key, or value/mask pair |
| matchFlag | output | 1 | Last search found a match |
| matchIndex | output | IDX_W | Lowest matching index of last search |
| activeValid | output | 1 | A write or delete took effect last cycle |
| activeAddr | output | IDX_W | Index touched by the last write or delete |
| full | output | 1 | Every entry valid |

## Verification
The bench builds the table with DEPTH = 8, which puts filling, overflow of write-next, and every free-slot position within a short run. With eight entries, five nested prefixes of lengths 32, 24, 16, 8 and 0 can be loaded next to exact entries. Every single-bit deviation of the key is then swept, so each prefix boundary decides the winner at least once. Every one of the 64 single-bit flips of an exact key is also searched, showing that no stored bit is ignored.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_SRCH_PFX = 3'd1,
    OP_SRCH_EX  = 3'd2,
    OP_WR_RAW   = 3'd3,
    OP_WR_ENC   = 3'd4,
    OP_WR_NEXT  = 3'd5,
    OP_DEL_IDX  = 3'd6,
    OP_DEL_KEY  = 3'd7
  } tcamOp_t;

  typedef struct packed {
    logic srchPfx;
    logic srchEx;
    logic wrRaw;
    logic wrEnc;
    logic wrNext;
    logic delIdx;
    logic delKey;
  } tcamStrobe_t;

endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
(
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output tcamStrobe_t stb
);

  tcamOp_t opCode;

  always_comb begin
    opCode = tcamOp_t'(cmdOp);
    stb = '0;
    if (cmdValid) begin
      unique case (opCode)
        OP_SRCH_PFX: stb.srchPfx = 1'b1;
        OP_SRCH_EX:  stb.srchEx  = 1'b1;
        OP_WR_RAW:   stb.wrRaw   = 1'b1;
        OP_WR_ENC:   stb.wrEnc   = 1'b1;
        OP_WR_NEXT:  stb.wrNext  = 1'b1;
        OP_DEL_IDX:  stb.delIdx  = 1'b1;
        OP_DEL_KEY:  stb.delKey  = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/tcam_datapath.sv
module tcam_datapath
  import tcam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcamStrobe_t       stb,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [WORD_W-1:0] cmdData,
  output logic              matchFlag,
  output logic [IDX_W-1:0]  matchIndex,
  output logic              activeValid,
  output logic [IDX_W-1:0]  activeAddr,
  output logic              full
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] entryQ [DEPTH];
  logic [DEPTH-1:0]  validQ;

  logic [DEPTH-1:0]  pfxHit;
  logic [DEPTH-1:0]  exHit;
  logic [DEPTH-1:0]  selHit;

  logic [HALF_W-1:0] keyHalf;
  logic [HALF_W-1:0] encVal;
  logic [HALF_W-1:0] encMask;
  logic [WORD_W-1:0] wrData;

  logic              hitFound;
  logic [IDX_W-1:0]  hitIdx;
  logic              freeFound;
  logic [IDX_W-1:0]  freeIdx;
  logic              idxInRange;

  logic              doWrite;
  logic              doDelete;
  logic [IDX_W-1:0]  tgtIdx;

  assign keyHalf = cmdData[HALF_W-1:0];
  assign encVal  = cmdData[HALF_W-1:0];
  assign encMask = cmdData[WORD_W-1:HALF_W];

  // Per-entry comparators: a pair mismatches when the key selects a half holding 1
  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    logic [HALF_W-1:0] loHalf;
    logic [HALF_W-1:0] hiHalf;
    assign loHalf    = entryQ[e][HALF_W-1:0];
    assign hiHalf    = entryQ[e][WORD_W-1:HALF_W];
    assign pfxHit[e] = validQ[e] & ~|((keyHalf & hiHalf) | (~keyHalf & loHalf));
    assign exHit[e]  = validQ[e] & (entryQ[e] == cmdData);
  end

  assign selHit = stb.srchPfx ? pfxHit : exHit;

  // Lowest set bit of a vector, fixed depth regardless of contents
  function automatic logic [IDX_W:0] lowestSet(input logic [DEPTH-1:0] vec);
    logic [IDX_W:0] res;
    res = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) res = {1'b1, IDX_W'(i)};
    end
    return res;
  endfunction

  always_comb begin
    {hitFound, hitIdx}   = lowestSet(selHit);
    {freeFound, freeIdx} = lowestSet(~validQ);
  end

  assign idxInRange = (32'(cmdIndex) < DEPTH);

  always_comb begin
    wrData = stb.wrEnc ? {~encVal & encMask, encVal & encMask} : cmdData;
    if (stb.wrNext)      tgtIdx = freeIdx;
    else if (stb.delKey) tgtIdx = hitIdx;
    else                 tgtIdx = cmdIndex;
    doWrite  = ((stb.wrRaw | stb.wrEnc) & idxInRange) | (stb.wrNext & freeFound);
    doDelete = (stb.delIdx & idxInRange) | (stb.delKey & hitFound);
  end

  // Storage array and validity
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (doWrite && tgtIdx == IDX_W'(i)) entryQ[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tgtIdx == IDX_W'(i)) begin
          if (doWrite)       validQ[i] <= 1'b1;
          else if (doDelete) validQ[i] <= 1'b0;
        end
      end
    end
  end

  // Registered search result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchFlag  <= 1'b0;
      matchIndex <= '0;
    end else if (stb.srchPfx || stb.srchEx) begin
      matchFlag  <= hitFound;
      matchIndex <= hitFound ? hitIdx : '0;
    end
  end

  // Registered active address for the companion RAM
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeValid <= 1'b0;
      activeAddr  <= '0;
    end else begin
      activeValid <= doWrite | doDelete;
      if (doWrite || doDelete) activeAddr <= tgtIdx;
    end
  end

  assign full = &validQ;

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [WORD_W-1:0] cmdData,
  output logic              matchFlag,
  output logic [IDX_W-1:0]  matchIndex,
  output logic              activeValid,
  output logic [IDX_W-1:0]  activeAddr,
  output logic              full
);

  tcamStrobe_t stb;

  tcam_ctrl uCtrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .stb      (stb)
  );

  tcam_datapath #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cmdIndex    (cmdIndex),
    .cmdData     (cmdData),
    .matchFlag   (matchFlag),
    .matchIndex  (matchIndex),
    .activeValid (activeValid),
    .activeAddr  (activeAddr),
    .full        (full)
  );

endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic [IDX_W-1:0] cmdIndex,
  input logic             matchFlag,
  input logic [IDX_W-1:0] matchIndex,
  input logic             activeValid,
  input logic [IDX_W-1:0] activeAddr,
  input logic             full
);

  logic isSearch;
  assign isSearch = cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isSearch |=> $stable(matchFlag) && $stable(matchIndex));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !matchFlag |-> matchIndex == '0);

  // R7
  write_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdOp == 3'd3 || cmdOp == 3'd4) |=> activeValid && activeAddr == $past(cmdIndex));

  // R8
  next_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd5 && full |=> !activeValid && full);

  // R9
  del_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd6 |=> activeValid && activeAddr == $past(cmdIndex) && !full);

  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(full) |-> $past(cmdValid && (cmdOp == 3'd6 || cmdOp == 3'd7)));

endmodule

bind tcam_lookup tcam_lookup_chk #(.IDX_W(IDX_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdOp       (cmdOp),
  .cmdIndex    (cmdIndex),
  .matchFlag   (matchFlag),
  .matchIndex  (matchIndex),
  .activeValid (activeValid),
  .activeAddr  (activeAddr),
  .full        (full)
);

// File: tb/sim_tcam_lookup.sv
`timescale 1ns/1ps
module sim_tcam_lookup;

  localparam int DEPTH = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [2:0]       cmdOp = '0;
  logic [IDX_W-1:0] cmdIndex = '0;
  logic [63:0]      cmdData = '0;
  logic             matchFlag;
  logic [IDX_W-1:0] matchIndex;
  logic             activeValid;
  logic [IDX_W-1:0] activeAddr;
  logic             full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] mEntry [DEPTH];
  logic        mValid [DEPTH];

  always #2.5 clk = ~clk;

  tcam_lookup #(.DEPTH(DEPTH), .WORD_W(64), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdIndex(cmdIndex), .cmdData(cmdData), .matchFlag(matchFlag),
    .matchIndex(matchIndex), .activeValid(activeValid),
    .activeAddr(activeAddr), .full(full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int idx, input logic [63:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIndex = IDX_W'(idx); cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  // Digit-wise decode of stored pairs
  function automatic bit pfxMatch(input logic [63:0] s, input logic [31:0] k);
    for (int n = 0; n < 32; n++) begin
      if (s[n] && s[n+32]) return 1'b0;
      if (s[n] && !k[n]) return 1'b0;
      if (s[n+32] && k[n]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int expHit(input bit pfx, input logic [63:0] key);
    for (int i = 0; i < DEPTH; i++) begin
      if (mValid[i] && (pfx ? pfxMatch(mEntry[i], key[31:0]) : (mEntry[i] == key))) return i;
    end
    return -1;
  endfunction

  function automatic bit mFull();
    for (int i = 0; i < DEPTH; i++) if (!mValid[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic search(input string req, input bit pfx, input logic [63:0] key);
    int h;
    h = expHit(pfx, key);
    issue(pfx ? 3'd1 : 3'd2, 0, key);
    chk(req, {63'd0, matchFlag}, {63'd0, h >= 0});
    chk(req, {61'd0, matchIndex}, h >= 0 ? 64'(h) : 64'd0);
  endtask

  task automatic writeEnc(input int idx, input logic [31:0] a, input logic [31:0] m);
    issue(3'd4, idx, {m, a});
    mEntry[idx] = {~a & m, a & m}; mValid[idx] = 1'b1;
    chk("R7", {63'd0, activeValid}, 64'd1);
    chk("R7", {61'd0, activeAddr}, 64'(idx));
  endtask

  function automatic logic [31:0] pfxMask(input int len);
    return (len == 0) ? 32'd0 : (32'hFFFF_FFFF << (32 - len));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    logic [63:0] exKey;
    logic [63:0] nextA;
    logic [63:0] nextB;
    for (int i = 0; i < DEPTH; i++) begin mValid[i] = 1'b0; mEntry[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", {63'd0, matchFlag}, 64'd0);
    chk("R1", {61'd0, matchIndex}, 64'd0);
    chk("R1", {63'd0, activeValid}, 64'd0);
    chk("R1", {63'd0, full}, 64'd0);
    search("R1", 1'b1, 64'd0);

    // R3 encoded prefixes, longest first
    base = 32'hC0A8_0105;
    writeEnc(0, base, pfxMask(32));
    writeEnc(1, base, pfxMask(24));
    writeEnc(2, base, pfxMask(16));
    writeEnc(3, base, pfxMask(8));
    writeEnc(4, 32'h1234_5678, pfxMask(0));
    chk("R11", {63'd0, full}, 64'd0);

    // R4 R6 sweep of single-bit deviations from the base key
    search("R4", 1'b1, {32'd0, base});
    for (int b = 0; b < 32; b++) search("R6", 1'b1, {32'd0, base ^ (32'd1 << b)});
    search("R4", 1'b1, 64'h0000_0000_FFFF_FFFF);

    // R5 exact entry and all single-bit flips
    exKey = 64'h0000_1234_5678_9ABC;
    issue(3'd3, 6, exKey);
    mEntry[6] = exKey; mValid[6] = 1'b1;
    chk("R7", {61'd0, activeAddr}, 64'd6);
    search("R5", 1'b0, exKey);
    for (int b = 0; b < 64; b++) search("R5", 1'b0, exKey ^ (64'd1 << b));

    // R2 idle keeps last result
    search("R2", 1'b0, exKey);
    issue(3'd0, 0, 64'd0);
    chk("R2", {63'd0, matchFlag}, 64'd1);
    chk("R2", {61'd0, matchIndex}, 64'd6);
    issue(3'd6, 7, 64'd0);
    chk("R2", {61'd0, matchIndex}, 64'd6);

    // R8 write-next fills 5 then 7, then refuses
    nextA = 64'hAAAA_0000_0000_0001;
    nextB = 64'hBBBB_0000_0000_0002;
    issue(3'd5, 0, nextA);
    mEntry[5] = nextA; mValid[5] = 1'b1;
    chk("R8", {63'd0, activeValid}, 64'd1);
    chk("R8", {61'd0, activeAddr}, 64'd5);
    chk("R11", {63'd0, full}, 64'd0);
    issue(3'd5, 0, nextB);
    mEntry[7] = nextB; mValid[7] = 1'b1;
    chk("R8", {61'd0, activeAddr}, 64'd7);
    chk("R11", {63'd0, full}, {63'd0, mFull()});
    issue(3'd5, 0, 64'hDEAD_BEEF_0000_0000);
    chk("R8", {63'd0, activeValid}, 64'd0);
    chk("R8", {63'd0, full}, 64'd1);
    search("R8", 1'b0, 64'hDEAD_BEEF_0000_0000);
    search("R8", 1'b0, nextB);

    // R9 delete by index shifts the best prefix
    issue(3'd6, 0, 64'd0);
    mValid[0] = 1'b0;
    chk("R9", {63'd0, activeValid}, 64'd1);
    chk("R9", {61'd0, activeAddr}, 64'd0);
    chk("R11", {63'd0, full}, 64'd0);
    search("R9", 1'b1, {32'd0, base});

    // R10 delete by key, hit and miss
    issue(3'd7, 0, exKey);
    mValid[6] = 1'b0;
    chk("R10", {63'd0, activeValid}, 64'd1);
    chk("R10", {61'd0, activeAddr}, 64'd6);
    search("R10", 1'b0, exKey);
    issue(3'd7, 0, 64'h0123_4567_89AB_CDEF);
    chk("R10", {63'd0, activeValid}, 64'd0);
    chk("R10", {61'd0, activeAddr}, 64'd6);

    // R8 next free is now the lowest hole
    issue(3'd5, 0, exKey);
    mEntry[0] = exKey; mValid[0] = 1'b1;
    chk("R8", {61'd0, activeAddr}, 64'd0);
    search("R8", 1'b0, exKey);
    search("R4", 1'b1, {32'd0, base});

    // R7 raw overwrite of a valid entry
    issue(3'd3, 1, nextA);
    mEntry[1] = nextA; mValid[1] = 1'b1;
    search("R7", 1'b1, {32'd0, base ^ 32'h0000_0001});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule